// File: doc/BRIEF.md
# Multi-Device SYNC Combiner with Alignment-Start Gate

This block sits on the transmit side of a multi-converter serial link and runs in the frame clock domain, one clock cycle per frame. Every converter drives its own active-low SYNC request line. The block brings each line into the frame domain through its own two-stage synchronizer. It then merges the enabled lines into one link-wide request and drives that request back out through one register per device. The combined request is what every device sees, and all of those copies change on the same frame edge.

A small link controller watches the combined request. After reset, or after a resynchronization request, it waits until every enabled device has released SYNC. It then waits for the next multiframe boundary and issues a one-frame start strobe for the initial lane alignment sequence. That strobe reaches every lane in the same cycle. A free-running frame counter marks the multiframe boundaries.

While data is flowing, a low on the combined request is classified. When error reporting is enabled, a low shorter than a programmable number of frames counts as an error report: the block gives a one-cycle flag and the link stays up. A low of that length or longer means the link must realign. When error reporting is disabled, any low at all means the link must realign.

Top module: `sync_merge_ilas`

## Requirements
- R1: Every copy of `sync_n_out` equals the AND, over all devices, of (`sync_n_in` bit OR NOT `dev_en` bit). The `sync_n_in` value used is the one sampled three rising edges earlier. So any enabled device driving low makes the output low.
- R2: A device whose `dev_en` bit is 0 has no effect on `sync_n_out`, on `ilas_start` or on `err_rep`, even when its input is held low.
- R3: All bits of `sync_n_out` are equal in every cycle.
- R4: All bits of `ilas_start` are equal in every cycle. A strobe lasts exactly one cycle. A strobe is issued only when the combined request was high at the edge that set it.
- R5: After the combined request is released while the link is waiting, `ilas_start` goes high for one cycle. This happens in the first cycle whose frame count within the multiframe is 0, counting frames from reset. Exactly one strobe is issued per release.
- R6: With `err_rep_en`=1, a combined low of L cycles during data, where 1 <= L < `err_len`, gives a one-cycle `err_rep`. `err_rep` rises in the cycle after the combined request comes back high. No new `ilas_start` follows.
- R7: During data, a combined low of `err_len` cycles or more makes the link realign. With `err_rep_en`=0, a combined low of any length does the same. Realignment means a new `ilas_start` after the release, and no `err_rep`.
- R8: During reset, `sync_n_out`, `ilas_start` and `err_rep` are all 0. The frame counter restarts at 0 when reset is released.
- R9: If the combined request goes low while the link is waiting for a boundary, the pending strobe is cancelled. One release still leads to exactly one strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n_in | input | N_DEV | Asynchronous active-low SYNC request, one bit per device |
| dev_en | input | N_DEV | Per-device enable mask for the merge |
| err_rep_en | input | 1 | 1: short lows are error reports; 0: any low forces realignment |
| err_len | input | CW | Low length, in frames, at which a low becomes a realignment request |
| sync_n_out | output | N_DEV | Registered combined SYNC request, one copy per device |
| ilas_start | output | N_LANES | One-cycle start strobe for the alignment sequence, one bit per lane |
| err_rep | output | 1 | One-cycle flag for a short low classified as an error report |

## Verification
Two events can land in the same cycle. One is the combined request coming back high. The other is a multiframe boundary. Depending on the link state, that release should produce either the alignment strobe or an error-report flag. The bench provokes this overlap by sweeping the release point across every frame position of the multiframe, both after long realignment lows and after short error-report lows. It also inserts a one-frame dip right after a release to test the cancel path. A behavioural model predicts every output in every cycle and judges the result, together with per-scenario counts of strobes and error flags.

// File: rtl/sync_merge_pkg.sv
package sync_merge_pkg;

  typedef enum logic [1:0] {
    ST_REQ  = 2'd0,
    ST_WAIT = 2'd1,
    ST_DATA = 2'd2
  } link_st_t;

endpackage

// File: rtl/sync_cell.sv
module sync_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic d_n,
  output logic q_n
);

  logic meta_q;

  // Both stages reset to 0, so reset reads as an active request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      q_n    <= 1'b0;
    end else begin
      meta_q <= d_n;
      q_n    <= meta_q;
    end
  end

endmodule

// File: rtl/sync_combine.sv
module sync_combine #(
  parameter int N_DEV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DEV-1:0] req_n_s,
  input  logic [N_DEV-1:0] dev_en,
  output logic             comb_n,
  output logic [N_DEV-1:0] sync_n_out
);

  // Masked-off devices read as released
  function automatic logic merge_req(input logic [N_DEV-1:0] r, input logic [N_DEV-1:0] m);
    return &(r | ~m);
  endfunction

  assign comb_n = merge_req(req_n_s, dev_en);

  // One register per device, all loaded from the same combined value
  for (genvar g = 0; g < N_DEV; g++) begin : g_fan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_n_out[g] <= 1'b0;
      else        sync_n_out[g] <= comb_n;
    end
  end

endmodule

// File: rtl/ilas_ctrl.sv
module ilas_ctrl
  import sync_merge_pkg::*;
#(
  parameter int N_LANES   = 4,
  parameter int MF_FRAMES = 4,
  parameter int CW        = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               comb_n,
  input  logic               err_rep_en,
  input  logic [CW-1:0]      err_len,
  output logic [N_LANES-1:0] ilas_start,
  output logic               err_rep,
  output logic               mf_first
);

  localparam int             MFW     = (MF_FRAMES > 1) ? $clog2(MF_FRAMES) : 1;
  localparam logic [MFW-1:0] MF_LAST = MFW'(MF_FRAMES - 1);
  localparam logic [CW-1:0]  RUN_MAX = {CW{1'b1}};

  link_st_t      st, st_nx;
  logic [MFW-1:0] mf_cnt;
  logic [CW-1:0]  low_run;
  logic           mf_last, ilas_fire, err_fire, resync;

  // Saturating count of consecutive low frames
  function automatic logic [CW-1:0] run_step(input logic [CW-1:0] r);
    return (r == RUN_MAX) ? r : r + 1'b1;
  endfunction

  // This low frame makes the run reach the limit
  function automatic logic run_at_limit(input logic [CW-1:0] r, input logic [CW-1:0] lim);
    return ((CW+1)'(r) + (CW+1)'(1)) >= (CW+1)'(lim);
  endfunction

  assign mf_last   = (mf_cnt == MF_LAST);
  assign mf_first  = (mf_cnt == '0);
  assign ilas_fire = (st == ST_WAIT) && comb_n && mf_last;
  assign err_fire  = (st == ST_DATA) && comb_n && (low_run != '0);
  assign resync    = !comb_n && (!err_rep_en || run_at_limit(low_run, err_len));

  always_comb begin
    st_nx = st;
    case (st)
      ST_REQ:  if (comb_n) st_nx = ST_WAIT;
      ST_WAIT: if (!comb_n) st_nx = ST_REQ;
               else if (mf_last) st_nx = ST_DATA;
      ST_DATA: if (resync) st_nx = ST_REQ;
      default: st_nx = ST_REQ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_REQ;
      mf_cnt  <= '0;
      low_run <= '0;
      err_rep <= 1'b0;
    end else begin
      st      <= st_nx;
      mf_cnt  <= mf_last ? '0 : mf_cnt + 1'b1;
      low_run <= comb_n ? '0 : run_step(low_run);
      err_rep <= err_fire;
    end
  end

  // Per-lane start registers share one next-state term
  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ilas_start[l] <= 1'b0;
      else        ilas_start[l] <= ilas_fire;
    end
  end

endmodule

// File: rtl/sync_merge_ilas.sv
module sync_merge_ilas #(
  parameter int N_DEV     = 4,
  parameter int N_LANES   = 4,
  parameter int MF_FRAMES = 4,
  parameter int CW        = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_DEV-1:0]   sync_n_in,
  input  logic [N_DEV-1:0]   dev_en,
  input  logic               err_rep_en,
  input  logic [CW-1:0]      err_len,
  output logic [N_DEV-1:0]   sync_n_out,
  output logic [N_LANES-1:0] ilas_start,
  output logic               err_rep
);

  logic [N_DEV-1:0] req_n_s;
  logic             comb_n;
  logic             mf_first;

  for (genvar d = 0; d < N_DEV; d++) begin : g_sync
    sync_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .d_n   (sync_n_in[d]),
      .q_n   (req_n_s[d])
    );
  end

  sync_combine #(.N_DEV(N_DEV)) u_comb (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_n_s    (req_n_s),
    .dev_en     (dev_en),
    .comb_n     (comb_n),
    .sync_n_out (sync_n_out)
  );

  ilas_ctrl #(.N_LANES(N_LANES), .MF_FRAMES(MF_FRAMES), .CW(CW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .comb_n     (comb_n),
    .err_rep_en (err_rep_en),
    .err_len    (err_len),
    .ilas_start (ilas_start),
    .err_rep    (err_rep),
    .mf_first   (mf_first)
  );

endmodule

// File: rtl/sync_merge_ilas_chk.sv
module sync_merge_ilas_chk #(
  parameter int N_DEV   = 4,
  parameter int N_LANES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_DEV-1:0]   sync_n_in,
  input logic [N_DEV-1:0]   dev_en,
  input logic               comb_n,
  input logic               mf_first,
  input logic [N_DEV-1:0]   sync_n_out,
  input logic [N_LANES-1:0] ilas_start,
  input logic               err_rep
);

  logic [2:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cyc <= '0;
    else if (cyc != 3'd7) cyc <= cyc + 1'b1;
  end

  p_merge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd4) |-> (sync_n_out[0] == &($past(sync_n_in, 3) | ~$past(dev_en, 1))));

  p_copies_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (&sync_n_out) || !(|sync_n_out));

  p_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (&ilas_start) || !(|ilas_start));

  p_ilas_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ilas_start[0] |=> !ilas_start[0]);

  p_ilas_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ilas_start[0] |-> $past(comb_n));

  p_ilas_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ilas_start[0] |-> mf_first);

  p_err_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_rep |-> !ilas_start[0]);

  p_err_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_rep |-> ($past(comb_n) && !$past(comb_n, 2)));

endmodule

bind sync_merge_ilas sync_merge_ilas_chk #(.N_DEV(N_DEV), .N_LANES(N_LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sync_n_in  (sync_n_in),
  .dev_en     (dev_en),
  .comb_n     (comb_n),
  .mf_first   (mf_first),
  .sync_n_out (sync_n_out),
  .ilas_start (ilas_start),
  .err_rep    (err_rep)
);

// File: tb/sync_merge_ilas_tb.sv
`timescale 1ns/1ps
module sync_merge_ilas_tb;

  localparam int ND = 4;
  localparam int NL = 4;
  localparam int MF = 4;
  localparam int CW = 4;
  localparam int RUN_SAT = (1 << CW) - 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic [ND-1:0] sync_n_in, dev_en;
  logic          err_rep_en;
  logic [CW-1:0] err_len;
  logic [ND-1:0] sync_n_out;
  logic [NL-1:0] ilas_start;
  logic          err_rep;

  sync_merge_ilas #(.N_DEV(ND), .N_LANES(NL), .MF_FRAMES(MF), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sync_n_in(sync_n_in), .dev_en(dev_en),
    .err_rep_en(err_rep_en), .err_len(err_len), .sync_n_out(sync_n_out),
    .ilas_start(ilas_start), .err_rep(err_rep));

  int checks = 0, errors = 0;
  bit done = 0;

  // Behavioural reference: input history queue plus link state as integers
  logic [ND-1:0] hist[$];
  int  st_m, run_m, mfc_m;
  bit  out_m, ilas_m, err_m;
  int  ilas_cnt, err_cnt;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic void model_reset();
    hist.delete();
    repeat (3) hist.push_back('0);
    st_m = 0; run_m = 0; mfc_m = 0;
    out_m = 0; ilas_m = 0; err_m = 0;
  endfunction

  function automatic void model_step();
    bit c;
    hist.push_front(sync_n_in);
    void'(hist.pop_back());
    c = &(hist[2] | ~dev_en);
    out_m  = c;
    ilas_m = (st_m == 1) && c && (mfc_m == MF - 1);
    err_m  = (st_m == 2) && c && (run_m != 0);
    case (st_m)
      0: st_m = c ? 1 : 0;
      1: st_m = !c ? 0 : ((mfc_m == MF - 1) ? 2 : 1);
      default: if (!c && (!err_rep_en || run_m + 1 >= int'(err_len))) st_m = 0;
    endcase
    run_m = c ? 0 : ((run_m < RUN_SAT) ? run_m + 1 : run_m);
    mfc_m = (mfc_m + 1) % MF;
    if (ilas_m) ilas_cnt++;
    if (err_m)  err_cnt++;
  endfunction

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      chk("R1 merged request", 32'(sync_n_out[0]), 32'(out_m));
      chk("R3 equal copies", 32'(sync_n_out), 32'({ND{out_m}}));
      chk("R4 lane strobes", 32'(ilas_start), 32'({NL{ilas_m}}));
      chk("R6 error flag", 32'(err_rep), 32'(err_m));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R5 actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int i0, e0;
    rst_n = 0; sync_n_in = '1; dev_en = '1; err_rep_en = 1; err_len = 4'd4;
    ilas_cnt = 0; err_cnt = 0;
    model_reset();
    repeat (3) @(negedge clk);
    // R8: reset values
    chk("R8 reset sync_n_out", 32'(sync_n_out), 0);
    chk("R8 reset ilas_start", 32'(ilas_start), 0);
    chk("R8 reset err_rep", 32'(err_rep), 0);
    sync_n_in = '0;
    rst_n = 1;
    tick(3);

    // R5: release at every multiframe offset, after a long realignment low
    for (int off = 0; off < MF; off++) begin
      sync_n_in = '0;
      tick(8 + off);
      i0 = ilas_cnt;
      sync_n_in = '1;
      tick(12);
      chk("R5 one strobe per release", 32'(ilas_cnt - i0), 1);
    end

    // R6: short lows in data, swept across offsets and devices
    for (int len = 1; len < 4; len++) begin
      for (int off = 0; off < MF; off++) begin
        tick(off);
        i0 = ilas_cnt; e0 = err_cnt;
        sync_n_in = '1; sync_n_in[(len + off) % ND] = 1'b0;
        tick(len);
        sync_n_in = '1;
        tick(8);
        chk("R6 one error report", 32'(err_cnt - e0), 1);
        chk("R6 no realignment", 32'(ilas_cnt - i0), 0);
      end
    end

    // R7: low equal to the limit forces realignment
    i0 = ilas_cnt; e0 = err_cnt;
    sync_n_in = 4'b1101;
    tick(4);
    sync_n_in = '1;
    tick(12);
    chk("R7 limit-length low realigns", 32'(ilas_cnt - i0), 1);
    chk("R7 no error report", 32'(err_cnt - e0), 0);

    // R7: reporting disabled, a single-frame low realigns
    err_rep_en = 0;
    i0 = ilas_cnt; e0 = err_cnt;
    sync_n_in = 4'b0111;
    tick(1);
    sync_n_in = '1;
    tick(12);
    chk("R7 disabled reporting realigns", 32'(ilas_cnt - i0), 1);
    chk("R7 disabled reporting no flag", 32'(err_cnt - e0), 0);
    err_rep_en = 1;

    // R2: masked device held low is ignored
    dev_en = 4'b0111;
    tick(2);
    i0 = ilas_cnt; e0 = err_cnt;
    sync_n_in = 4'b0111;
    tick(20);
    chk("R2 masked low keeps output high", 32'(sync_n_out), 32'({ND{1'b1}}));
    chk("R2 masked low no strobe", 32'(ilas_cnt - i0), 0);
    chk("R2 masked low no flag", 32'(err_cnt - e0), 0);
    // an enabled device still merges in (R1)
    sync_n_in = 4'b0110;
    tick(6);
    sync_n_in = 4'b0111;
    tick(12);
    chk("R1 enabled device realigns", 32'(ilas_cnt - i0), 1);
    dev_en = '1; sync_n_in = '1;
    tick(4);

    // R9: dip while waiting for the boundary, at every offset
    for (int off = 0; off < MF; off++) begin
      sync_n_in = '0;
      tick(8 + off);
      i0 = ilas_cnt;
      sync_n_in = '1;
      tick(1);
      sync_n_in = 4'b1011;
      tick(1);
      sync_n_in = '1;
      tick(14);
      chk("R9 single strobe after dip", 32'(ilas_cnt - i0), 1);
    end

    // R8: mid-run reset
    rst_n = 0;
    #1;
    chk("R8 async reset sync_n_out", 32'(sync_n_out), 0);
    chk("R8 async reset ilas_start", 32'(ilas_start), 0);
    @(negedge clk);
    model_reset();
    rst_n = 1;
    tick(12);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule